// File: doc/BRIEF.md
# Block Floating Point Pass Rescaler

This block sits between the passes of a radix-4 FFT data path. Each butterfly result arrives as a 19-bit real and imaginary pair. The block cuts each component to a 16-bit stored word through a growth window. On the first pass of a transform the window is always 2 bits. On every later pass the window is 2 or 3 bits, chosen once per transform.

While a pass runs, the block finds how far the whole block of stored words could be shifted left so that its largest-magnitude value keeps exactly one sign bit. It reports that shift count when the pass closes, and the next pass uses it to normalise its inputs. The block also keeps a running block exponent, which is the scale tag of the transform. On later 2-bit passes it raises a sticky overflow flag when a discarded top bit was not a sign copy. When two real blocks are interleaved onto the real and imaginary lanes, they share the same tracking, so the shift covers both.

A small state machine has three states. IDLE waits for a pass. RUN accepts samples. DONE publishes the pass result for one cycle. Its transitions are:
- IDLE→RUN when `pass_start` is high.
- RUN→DONE when `pass_end` is high.
- DONE→IDLE always.

Top module: `bfp_rescaler`

## Requirements
- R1: After reset the state is IDLE. `out_valid`, `shift_vld` and `ovf` are 0, and `exponent` is 0.
- R2: On a pass flagged first (`first_pass` high at `pass_start`), each accepted component is stored as bits 17..2 of its 19-bit input, whatever the growth mode. `re_out`/`im_out` show the words with `out_valid` high one cycle after the sample is accepted.
- R3: On a later pass, growth mode 1 stores bits 18..3 and growth mode 0 stores bits 17..2.
- R4: The growth mode is taken from `grow3_sel` when `xfm_start` is accepted in IDLE. Changes of `grow3_sel` later in the transform have no effect.
- R5: One cycle after `pass_end` is accepted in RUN, `shift_vld` is high for exactly one cycle. At that point `shift_cnt` equals the smallest count, over all stored real and imaginary words of the pass, of bits below bit 15 that equal bit 15 before the first differing bit (range 0..15).
- R6: A sample accepted in the same cycle as `pass_end` takes part in that pass's shift count.
- R7: A pass whose stored words are all zero reports a shift of 0 and leaves `exponent` unchanged.
- R8: `exponent` (8-bit two's complement) is cleared when `xfm_start` is accepted. At the end of each pass with a nonzero word it changes by the growth bits of that pass minus the reported shift. It changes at no other time.
- R9: On a later pass in growth mode 0, `ovf` goes high one cycle after an accepted component whose bits 18 and 17 differ. It stays high until `xfm_start` is accepted.
- R10: Samples presented outside RUN are ignored: `out_valid` stays 0 and the shift count is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfm_start | input | 1 | Begin a new transform (acted on in IDLE) |
| pass_start | input | 1 | Begin a pass (acted on in IDLE) |
| first_pass | input | 1 | Pass being started is the first of the transform |
| grow3_sel | input | 1 | Later-pass growth: 1 = 3 bits, 0 = 2 bits |
| pass_end | input | 1 | Close the pass (acted on in RUN) |
| sample_valid | input | 1 | Butterfly result present |
| re_in | input | 19 | Real butterfly result |
| im_in | input | 19 | Imaginary butterfly result |
| re_out | output | 16 | Stored real word |
| im_out | output | 16 | Stored imaginary word |
| out_valid | output | 1 | Stored words valid |
| shift_vld | output | 1 | Pass result valid |
| shift_cnt | output | 4 | Common normalising left shift |
| exponent | output | 8 | Running block exponent |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The final sample of a pass and the pass close can arrive in the same cycle. The bench provokes this by raising `sample_valid` and `pass_end` together, with a last sample that has fewer redundant sign bits than the earlier ones. The reported shift must then come from that last sample and not from the earlier minimum, and the exponent must move by the matching amount.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bfp_state_t;
endpackage

// File: rtl/bfp_slice.sv
module bfp_slice #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  raw,
    input  logic             wide_win,
    input  logic             chk_en,
    output logic [OUT_W-1:0] word,
    output logic             guard_bad
);
    localparam int LSB_NARROW = IN_W - OUT_W - 1;
    localparam int LSB_WIDE   = IN_W - OUT_W;

    always_comb begin
        if (wide_win) begin
            word = raw[LSB_WIDE +: OUT_W];
        end else begin
            word = raw[LSB_NARROW +: OUT_W];
        end
        guard_bad = chk_en && (raw[IN_W-1] != raw[IN_W-2]);
    end
endmodule

// File: rtl/bfp_tracker.sv
module bfp_tracker #(
    parameter int OUT_W = 16,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [OUT_W-1:0] re_w,
    input  logic [OUT_W-1:0] im_w,
    output logic [SH_W-1:0]  min_nxt,
    output logic             nz_nxt
);
    localparam logic [SH_W-1:0] MAX_CNT = SH_W'(OUT_W - 1);

    logic [SH_W-1:0] min_q;
    logic            nz_q;
    logic [SH_W-1:0] cnt_re;
    logic [SH_W-1:0] cnt_im;

    function automatic logic [SH_W-1:0] sign_run(input logic [OUT_W-1:0] w);
        logic [SH_W-1:0] n;
        logic            go;
        n  = '0;
        go = 1'b1;
        for (int i = OUT_W - 2; i >= 0; i--) begin
            if (go && (w[i] == w[OUT_W-1])) begin
                n = n + 1'b1;
            end else begin
                go = 1'b0;
            end
        end
        return n;
    endfunction

    always_comb begin
        cnt_re  = sign_run(re_w);
        cnt_im  = sign_run(im_w);
        min_nxt = min_q;
        nz_nxt  = nz_q;
        if (upd) begin
            if (cnt_re < min_nxt) min_nxt = cnt_re;
            if (cnt_im < min_nxt) min_nxt = cnt_im;
            nz_nxt = nz_q || (re_w != '0) || (im_w != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            min_q <= MAX_CNT;
            nz_q  <= 1'b0;
        end else begin
            min_q <= min_nxt;
            nz_q  <= nz_nxt;
        end
    end
endmodule

// File: rtl/bfp_rescaler.sv
module bfp_rescaler
    import bfp_pkg::*;
#(
    parameter int IN_W  = 19,
    parameter int OUT_W = 16,
    parameter int EXP_W = 8,
    parameter int SH_W  = $clog2(OUT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfm_start,
    input  logic             pass_start,
    input  logic             first_pass,
    input  logic             grow3_sel,
    input  logic             pass_end,
    input  logic             sample_valid,
    input  logic [IN_W-1:0]  re_in,
    input  logic [IN_W-1:0]  im_in,
    output logic [OUT_W-1:0] re_out,
    output logic [OUT_W-1:0] im_out,
    output logic             out_valid,
    output logic             shift_vld,
    output logic [SH_W-1:0]  shift_cnt,
    output logic [EXP_W-1:0] exponent,
    output logic             ovf
);
    localparam int GROW_LO = IN_W - OUT_W - 1;

    bfp_state_t state_q, state_d;
    logic       grow3_q;
    logic       first_q;
    logic       in_idle;
    logic       in_run;
    logic       take;
    logic       close;
    logic       wide_win;
    logic       chk_en;
    logic [EXP_W-1:0] grow_bits;

    logic [1:0][IN_W-1:0]  raw_v;
    logic [1:0][OUT_W-1:0] word_v;
    logic [1:0]            bad_v;
    logic [SH_W-1:0]       min_nxt;
    logic                  nz_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and state-decoded outputs
    always_comb begin
        state_d = state_q;
        in_idle = 1'b0;
        in_run  = 1'b0;
        shift_vld = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_idle = 1'b1;
                if (pass_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                in_run = 1'b1;
                if (pass_end) state_d = ST_DONE;
            end
            ST_DONE: begin
                shift_vld = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take      = in_run && sample_valid;
    assign close     = in_run && pass_end;
    assign wide_win  = !first_q && grow3_q;
    assign chk_en    = !first_q && !grow3_q;
    assign grow_bits = wide_win ? EXP_W'(GROW_LO + 1) : EXP_W'(GROW_LO);
    assign raw_v[0]  = re_in;
    assign raw_v[1]  = im_in;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bfp_slice #(.IN_W(IN_W), .OUT_W(OUT_W)) u_slice (
            .raw      (raw_v[g]),
            .wide_win (wide_win),
            .chk_en   (chk_en),
            .word     (word_v[g]),
            .guard_bad(bad_v[g])
        );
    end

    bfp_tracker #(.OUT_W(OUT_W), .SH_W(SH_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (in_idle && pass_start),
        .upd    (take),
        .re_w   (word_v[0]),
        .im_w   (word_v[1]),
        .min_nxt(min_nxt),
        .nz_nxt (nz_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grow3_q   <= 1'b0;
            first_q   <= 1'b1;
            re_out    <= '0;
            im_out    <= '0;
            out_valid <= 1'b0;
            shift_cnt <= '0;
            exponent  <= '0;
            ovf       <= 1'b0;
        end else begin
            out_valid <= take;
            if (take) begin
                re_out <= word_v[0];
                im_out <= word_v[1];
                if (|bad_v) ovf <= 1'b1;
            end
            if (in_idle && xfm_start) begin
                grow3_q  <= grow3_sel;
                exponent <= '0;
                ovf      <= 1'b0;
            end
            if (in_idle && pass_start) first_q <= first_pass;
            if (close) begin
                if (nz_nxt) begin
                    shift_cnt <= min_nxt;
                    exponent  <= exponent + grow_bits - EXP_W'(min_nxt);
                end else begin
                    shift_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bfp_rescaler_chk.sv
module bfp_rescaler_chk
    import bfp_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfm_start,
    input logic             pass_end,
    input logic             sample_valid,
    input logic             out_valid,
    input logic             shift_vld,
    input logic [EXP_W-1:0] exponent,
    input logic             ovf,
    input bfp_state_t       state_q
);
    AST_SHIFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld |=> !shift_vld); // R5
    AST_SHIFT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_vld |-> $past(pass_end)); // R5
    AST_OUT_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_valid && state_q == ST_RUN)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !xfm_start) |=> ovf); // R9
    AST_EXP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfm_start && state_q == ST_IDLE) |=> (exponent == '0)); // R8
    AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exponent) |-> (shift_vld || $past(xfm_start))); // R8
endmodule

bind bfp_rescaler bfp_rescaler_chk #(.EXP_W(EXP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfm_start   (xfm_start),
    .pass_end    (pass_end),
    .sample_valid(sample_valid),
    .out_valid   (out_valid),
    .shift_vld   (shift_vld),
    .exponent    (exponent),
    .ovf         (ovf),
    .state_q     (state_q)
);

// File: tb/bfp_rescaler_bench.sv
module bfp_rescaler_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        xfm_start, pass_start, first_pass, grow3_sel, pass_end, sample_valid;
    logic [18:0] re_in, im_in;
    logic [15:0] re_out, im_out;
    logic        out_valid, shift_vld, ovf;
    logic [3:0]  shift_cnt;
    logic [7:0]  exponent;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bfp_rescaler u_bfp_rescaler (
        .clk(clk), .rst_n(rst_n), .xfm_start(xfm_start), .pass_start(pass_start),
        .first_pass(first_pass), .grow3_sel(grow3_sel), .pass_end(pass_end),
        .sample_valid(sample_valid), .re_in(re_in), .im_in(im_in),
        .re_out(re_out), .im_out(im_out), .out_valid(out_valid),
        .shift_vld(shift_vld), .shift_cnt(shift_cnt), .exponent(exponent), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        xfm_start = 0; pass_start = 0; first_pass = 0; pass_end = 0;
        sample_valid = 0; re_in = '0; im_in = '0;
    endtask

    task automatic new_xfm(input logic g3);
        @(negedge clk); idle_inputs(); xfm_start = 1; grow3_sel = g3;
        @(negedge clk); idle_inputs();
    endtask

    task automatic open_pass(input logic first);
        @(negedge clk); idle_inputs(); pass_start = 1; first_pass = first;
        @(negedge clk); idle_inputs();
    endtask

    // drive one sample (optionally with close) and sample outputs one cycle later
    task automatic put(input logic [18:0] re, input logic [18:0] im, input logic last);
        re_in = re; im_in = im; sample_valid = 1; pass_end = last;
        @(negedge clk); idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 out_valid", out_valid, 0);
        chk("R1 shift_vld", shift_vld, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 exponent", exponent, 0);
    endtask

    task automatic t_first_and_coincident();
        new_xfm(1);
        open_pass(1);
        put(19'd4000, 19'h7FFF8, 0);
        chk("R2 re word", re_out, 16'd1000);
        chk("R2 im word", im_out, 16'hFFFE);
        chk("R2 out_valid", out_valid, 1);
        put(19'd16000, 19'd0, 1);
        chk("R5 shift_vld", shift_vld, 1);
        chk("R6 coincident shift", shift_cnt, 3);
        chk("R8 exponent 2-3", exponent, 8'hFF);
        @(negedge clk);
        chk("R5 shift pulse ends", shift_vld, 0);
    endtask

    task automatic t_later_wide();
        open_pass(0);
        grow3_sel = 0;
        put(19'h08000, 19'd0, 0);
        chk("R3 R4 wide window", re_out, 16'h1000);
        @(negedge clk); pass_end = 1;
        @(negedge clk); idle_inputs();
        chk("R5 shift later pass", shift_cnt, 2);
        chk("R8 exponent -1+3-2", exponent, 0);
    endtask

    task automatic t_narrow_ovf();
        new_xfm(0);
        chk("R8 cleared", exponent, 0);
        open_pass(1);
        put(19'h60000, 19'd0, 1);
        chk("R2 first pass no ovf", ovf, 0);
        chk("R5 shift zero", shift_cnt, 0);
        chk("R8 exponent 2", exponent, 2);
        open_pass(0);
        put(19'h20000, 19'd0, 0);
        chk("R3 narrow window", re_out, 16'h8000);
        chk("R9 ovf set", ovf, 1);
        @(negedge clk); pass_end = 1;
        @(negedge clk); idle_inputs();
        chk("R8 exponent 4", exponent, 4);
        // all-zero pass
        open_pass(0);
        put(19'd0, 19'd0, 0);
        put(19'd0, 19'd0, 1);
        chk("R7 zero shift", shift_cnt, 0);
        chk("R7 exponent kept", exponent, 4);
        chk("R9 ovf sticky", ovf, 1);
        new_xfm(0);
        chk("R9 ovf cleared", ovf, 0);
    endtask

    task automatic t_idle_ignore();
        new_xfm(0);
        re_in = 19'h3FFFF; im_in = 19'h1000; sample_valid = 1;
        @(negedge clk); idle_inputs();
        chk("R10 out_valid idle", out_valid, 0);
        open_pass(1);
        put(19'd4, 19'd0, 1);
        chk("R10 shift unaffected", shift_cnt, 14);
        chk("R8 exponent 2-14", exponent, 8'hF4);
    endtask

    initial begin
        idle_inputs(); grow3_sel = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_first_and_coincident();
        t_later_wide();
        t_narrow_ovf();
        t_idle_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule